// File: doc/BRIEF.md
# Byte-Wide Host Port Bridge

This block connects an 8-bit parallel host bus to a processor that moves 24-bit words. The host sends a word by writing three byte registers: high, middle and low. The write to the low byte completes the word and hands it to a processor-side holding register. For the other direction, the processor posts a 24-bit word, and the host reads it back one byte at a time. Two flags in a host-readable status register tell the host when it may read and when it may write. A host command register carries an interrupt vector and a request bit. The processor sees the request as a level and clears it with an acknowledge pulse.

The eight pins have two modes, set by a mode register on the processor side. In host mode they form the host data bus. The bus can be non-multiplexed, where the address comes from dedicated lines, or multiplexed, where the address is latched from the pins by an address strobe. In GPIO mode each pin is an input or an output, set by its bit in a direction register. Pad tristate control is left to the chip, so each pin is shown as a separate input, output and output enable. All host strobes are synchronous one-cycle pulses sampled on the rising clock edge.

Host register addresses (3 bits):

- 0: command. Bit 7 is the request bit and bits 6:0 are the vector.
- 1: status, read-only.
- 5: high byte.
- 6: middle byte.
- 7: low byte.

Addresses 2 to 4 read as zero.

Top module: `hpb_bridge`

## Requirements
- R1: During and after reset these outputs hold: `pin_oe` = 0 (all pins inputs), `cpu_rx_full` = 0, `cpu_tx_ready` = 1 and `cpu_hreq` = 0. The mode register resets to GPIO with every direction bit set to input.
- R2: The host writes the byte registers at addresses 5, 6 and 7. The write to address 7 completes the word. From the next cycle, `cpu_rx_word` equals {high, middle, low}, `cpu_rx_full` = 1, and the status write-allowed bit reads 0.
- R3: While `cpu_rx_full` = 1, host writes to addresses 5 to 7 are ignored and `cpu_rx_word` holds. A `cpu_rx_rd` pulse clears `cpu_rx_full` and lets the host write again.
- R4: A `cpu_tx_wr` pulse while `cpu_tx_ready` = 1 loads `cpu_tx_word` into the host receive bytes and sets the status read-allowed bit. Reads of addresses 5, 6 and 7 return bits 23:16, 15:8 and 7:0. Only the read of address 7 clears the flag and raises `cpu_tx_ready` again.
- R5: A `cpu_tx_wr` pulse while `cpu_tx_ready` = 0 is ignored, and the host still reads the earlier word.
- R6: A host write of 1 to bit 7 of the command register, made while the request bit is clear, sets `cpu_hreq` and loads bits 6:0 into `cpu_vector`. A `cpu_ack` pulse clears `cpu_hreq`.
- R7: While `cpu_hreq` = 1, host writes to the command register are ignored, so `cpu_vector` stays stable. A host read of the command register returns {request, vector}.
- R8: The status register is read-only at address 1. Bit 0 means the host may read, bit 1 means the host may write, bit 2 is the request bit, and bits 7:3 are 0. Host writes to it change nothing.
- R9: With mode bits [1:0] = 2'b11 (bit 0 host mode, bit 1 multiplexed), the register address is taken from `pin_in[2:0]` at an `hale` pulse, and `haddr` is ignored.
- R10: With mode bit 0 = 0 (GPIO mode):
  - `pin_oe` equals the direction register.
  - `pin_out` shows the GPIO output register on the enabled pins.
  - `gpio_in` shows `pin_in` one cycle later.
  - Host strobes have no effect.
- R11: In host mode, a host read drives the addressed byte on `pin_out`, with `pin_oe` = 8'hFF, for exactly the one cycle after the read strobe. At all other times `pin_oe` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hcs | input | 1 | Host access strobe, one cycle |
| hwr | input | 1 | Access direction with `hcs`: 1 write, 0 read |
| hale | input | 1 | Address latch strobe (multiplexed mode) |
| haddr | input | 3 | Register address (non-multiplexed mode) |
| pin_in | input | 8 | Pin input values |
| pin_out | output | 8 | Pin output values |
| pin_oe | output | 8 | Pin output enables |
| cpu_rx_word | output | 24 | Word assembled by the host |
| cpu_rx_full | output | 1 | Host word waiting for the processor |
| cpu_rx_rd | input | 1 | Processor consumes the host word |
| cpu_tx_word | input | 24 | Word for the host |
| cpu_tx_wr | input | 1 | Processor posts `cpu_tx_word` |
| cpu_tx_ready | output | 1 | Host receive bytes free |
| cpu_hreq | output | 1 | Host command request |
| cpu_vector | output | 7 | Host command vector |
| cpu_ack | input | 1 | Processor acknowledges the request |
| cpu_cfg_wr | input | 1 | Configuration write strobe |
| cpu_cfg_sel | input | 2 | Target register: 0 mode, 1 direction, 2 GPIO output |
| cpu_cfg_data | input | 16 | Configuration write data |
| gpio_in | output | 8 | Sampled pin inputs in GPIO mode |

## Verification
The assertions assume the following about the inputs:
- The processor pulses `cpu_ack` only while a request is pending.
- Every host strobe lasts exactly one clock.
- An address latch happens in a different cycle from the access that uses it.

The bench drives every strobe at the falling edge, holds it for a single cycle, and always places `hale` in its own cycle before the access. It also follows the flag rules the host is meant to obey, except in the scenarios that deliberately break them to show that the offending write is dropped.

// File: rtl/hpb_pkg.sv
package hpb_pkg;
  localparam int HPB_DW     = 8;
  localparam int HPB_NBYTES = 3;
  localparam int HPB_AW     = 3;

  // host register addresses; lane i sits at HREG_LO_I - i
  localparam int HREG_CMD_I  = 0;
  localparam int HREG_STAT_I = 1;
  localparam int HREG_LO_I   = 7;

  // configuration targets on the processor side
  localparam logic [1:0] CFG_MODE = 2'd0;
  localparam logic [1:0] CFG_DIR  = 2'd1;
  localparam logic [1:0] CFG_GOUT = 2'd2;

  typedef struct packed {
    logic              wr;
    logic              rd;
    logic [HPB_AW-1:0] addr;
  } hacc_t;
endpackage

// File: rtl/hpb_addr_dec.sv
module hpb_addr_dec
  import hpb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_en,
  input  logic              mux_mode,
  input  logic              hcs,
  input  logic              hwr,
  input  logic              hale,
  input  logic [HPB_AW-1:0] haddr,
  input  logic [HPB_AW-1:0] pin_addr,
  output hacc_t             acc
);
  logic [HPB_AW-1:0] alat_q, alat_d;
  logic              alat_en;

  assign alat_en = host_en & mux_mode & hale;

  always_comb begin
    alat_d = alat_q;
    if (alat_en) alat_d = pin_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alat_q <= '0;
    else        alat_q <= alat_d;
  end

  always_comb begin
    acc.wr   = host_en & hcs & hwr;
    acc.rd   = host_en & hcs & ~hwr;
    acc.addr = mux_mode ? alat_q : haddr;
  end
endmodule

// File: rtl/hpb_host_regs.sv
module hpb_host_regs
  import hpb_pkg::*;
#(
  parameter int DW    = HPB_DW,
  parameter int NB    = HPB_NBYTES,
  parameter int VW    = 7,
  localparam int WW   = DW * NB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  hacc_t         acc,
  input  logic [DW-1:0] wdata,
  input  logic          cpu_rx_rd,
  input  logic [WW-1:0] cpu_tx_word,
  input  logic          cpu_tx_wr,
  input  logic          cpu_ack,
  output logic [WW-1:0] cpu_rx_word,
  output logic          cpu_rx_full,
  output logic          cpu_tx_ready,
  output logic          cpu_hreq,
  output logic [VW-1:0] cpu_vector,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          wr_lo,
  output logic [WW-1:0] rx_hold
);
  localparam logic [HPB_AW-1:0] ADDR_CMD  = HPB_AW'(HREG_CMD_I);
  localparam logic [HPB_AW-1:0] ADDR_STAT = HPB_AW'(HREG_STAT_I);
  localparam logic [HPB_AW-1:0] ADDR_LO   = HPB_AW'(HREG_LO_I);

  // host-to-processor path
  logic [DW-1:0] tx_lane_q [NB];
  logic [DW-1:0] tx_lane_d [NB];
  logic [NB-1:0] lane_we;
  logic [WW-1:0] asm_word;
  logic [WW-1:0] pword_q, pword_d;
  logic          pfull_q, pfull_d;
  logic          txde;

  // processor-to-host path
  logic [WW-1:0] rxw_q, rxw_d;
  logic          rxdf_q, rxdf_d;
  logic          cpu_load, rd_lo;

  // command handshake
  logic          hc_q, hc_d;
  logic [VW-1:0] vec_q, vec_d;
  logic          cmd_we;

  // read return
  logic [DW-1:0] rd_mux, rd_data_q, rd_data_d;
  logic          rd_valid_q;

  assign txde = ~pfull_q;

  for (genvar i = 0; i < NB; i++) begin : g_lane
    localparam logic [HPB_AW-1:0] LANE_ADDR = HPB_AW'(HREG_LO_I - i);
    assign lane_we[i]  = acc.wr & (acc.addr == LANE_ADDR) & txde;
    assign tx_lane_d[i] = lane_we[i] ? wdata : tx_lane_q[i];
    assign asm_word[i*DW +: DW] = tx_lane_d[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          tx_lane_q[i] <= '0;
      else if (lane_we[i]) tx_lane_q[i] <= tx_lane_d[i];
    end
  end

  assign wr_lo = lane_we[0];

  always_comb begin
    pword_d = pword_q;
    pfull_d = pfull_q;
    if (wr_lo) begin
      pword_d = asm_word;
      pfull_d = 1'b1;
    end else if (cpu_rx_rd) begin
      pfull_d = 1'b0;
    end
  end

  assign cpu_load = cpu_tx_wr & ~rxdf_q;
  assign rd_lo    = acc.rd & (acc.addr == ADDR_LO);

  always_comb begin
    rxw_d  = rxw_q;
    rxdf_d = rxdf_q;
    if (cpu_load) begin
      rxw_d  = cpu_tx_word;
      rxdf_d = 1'b1;
    end else if (rd_lo) begin
      rxdf_d = 1'b0;
    end
  end

  assign cmd_we = acc.wr & (acc.addr == ADDR_CMD) & ~hc_q;

  always_comb begin
    hc_d  = hc_q;
    vec_d = vec_q;
    if (cmd_we) begin
      hc_d  = wdata[DW-1];
      vec_d = wdata[VW-1:0];
    end else if (cpu_ack) begin
      hc_d  = 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (acc.addr == ADDR_CMD) begin
      rd_mux[DW-1]   = hc_q;
      rd_mux[VW-1:0] = vec_q;
    end else if (acc.addr == ADDR_STAT) begin
      rd_mux[0] = rxdf_q;
      rd_mux[1] = txde;
      rd_mux[2] = hc_q;
    end else begin
      for (int i = 0; i < NB; i++) begin
        if (acc.addr == HPB_AW'(HREG_LO_I - i)) rd_mux = rxw_q[i*DW +: DW];
      end
    end
  end

  always_comb begin
    rd_data_d = rd_data_q;
    if (acc.rd) rd_data_d = rd_mux;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pword_q    <= '0;
      pfull_q    <= 1'b0;
      rxw_q      <= '0;
      rxdf_q     <= 1'b0;
      hc_q       <= 1'b0;
      vec_q      <= '0;
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      pword_q    <= pword_d;
      pfull_q    <= pfull_d;
      rxw_q      <= rxw_d;
      rxdf_q     <= rxdf_d;
      hc_q       <= hc_d;
      vec_q      <= vec_d;
      rd_data_q  <= rd_data_d;
      rd_valid_q <= acc.rd;
    end
  end

  assign cpu_rx_word  = pword_q;
  assign cpu_rx_full  = pfull_q;
  assign cpu_tx_ready = ~rxdf_q;
  assign cpu_hreq     = hc_q;
  assign cpu_vector   = vec_q;
  assign rd_data      = rd_data_q;
  assign rd_valid     = rd_valid_q;
  assign rx_hold      = rxw_q;
endmodule

// File: rtl/hpb_pin_mux.sv
module hpb_pin_mux
  import hpb_pkg::*;
#(
  parameter int DW = HPB_DW,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [1:0]    cfg_sel,
  input  logic [CW-1:0] cfg_data,
  input  logic [DW-1:0] pin_in,
  input  logic [DW-1:0] rd_data,
  input  logic          rd_valid,
  output logic          host_en,
  output logic          mux_mode,
  output logic [DW-1:0] pin_out,
  output logic [DW-1:0] pin_oe,
  output logic [DW-1:0] gpio_in
);
  logic [1:0]    mode_q, mode_d;
  logic [DW-1:0] dir_q, dir_d;
  logic [DW-1:0] gout_q, gout_d;
  logic [DW-1:0] gin_q;
  logic          gin_en;
  logic          unused_cfg_hi;

  // upper bits of the mode word are reserved and dropped
  assign unused_cfg_hi = ^cfg_data[CW-1:DW];

  always_comb begin
    mode_d = mode_q;
    dir_d  = dir_q;
    gout_d = gout_q;
    if (cfg_wr) begin
      unique case (cfg_sel)
        CFG_MODE: mode_d = cfg_data[1:0];
        CFG_DIR:  dir_d  = cfg_data[DW-1:0];
        CFG_GOUT: gout_d = cfg_data[DW-1:0];
        default:  ;
      endcase
    end
  end

  assign gin_en = ~mode_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      dir_q  <= '0;
      gout_q <= '0;
    end else begin
      mode_q <= mode_d;
      dir_q  <= dir_d;
      gout_q <= gout_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gin_q <= '0;
    else if (gin_en) gin_q <= pin_in;
  end

  assign host_en  = mode_q[0];
  assign mux_mode = mode_q[1];
  assign gpio_in  = gin_q;

  always_comb begin
    if (host_en) begin
      pin_oe  = {DW{rd_valid}};
      pin_out = rd_valid ? rd_data : '0;
    end else begin
      pin_oe  = dir_q;
      pin_out = gout_q & dir_q;
    end
  end
endmodule

// File: rtl/hpb_bridge.sv
module hpb_bridge
  import hpb_pkg::*;
#(
  parameter int DATA_W = HPB_DW,
  parameter int NBYTES = HPB_NBYTES,
  parameter int VEC_W  = 7,
  parameter int CFG_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     hcs,
  input  logic                     hwr,
  input  logic                     hale,
  input  logic [HPB_AW-1:0]        haddr,
  input  logic [DATA_W-1:0]        pin_in,
  output logic [DATA_W-1:0]        pin_out,
  output logic [DATA_W-1:0]        pin_oe,
  output logic [DATA_W*NBYTES-1:0] cpu_rx_word,
  output logic                     cpu_rx_full,
  input  logic                     cpu_rx_rd,
  input  logic [DATA_W*NBYTES-1:0] cpu_tx_word,
  input  logic                     cpu_tx_wr,
  output logic                     cpu_tx_ready,
  output logic                     cpu_hreq,
  output logic [VEC_W-1:0]         cpu_vector,
  input  logic                     cpu_ack,
  input  logic                     cpu_cfg_wr,
  input  logic [1:0]               cpu_cfg_sel,
  input  logic [CFG_W-1:0]         cpu_cfg_data,
  output logic [DATA_W-1:0]        gpio_in
);
  localparam int WORD_W = DATA_W * NBYTES;

  hacc_t             acc;
  logic              host_en, mux_mode;
  logic [DATA_W-1:0] rd_data;
  logic              rd_valid;
  logic              wr_lo;
  logic [WORD_W-1:0] rx_hold;

  hpb_addr_dec dec_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .host_en  (host_en),
    .mux_mode (mux_mode),
    .hcs      (hcs),
    .hwr      (hwr),
    .hale     (hale),
    .haddr    (haddr),
    .pin_addr (pin_in[HPB_AW-1:0]),
    .acc      (acc)
  );

  hpb_host_regs #(.DW(DATA_W), .NB(NBYTES), .VW(VEC_W)) regs_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc          (acc),
    .wdata        (pin_in),
    .cpu_rx_rd    (cpu_rx_rd),
    .cpu_tx_word  (cpu_tx_word),
    .cpu_tx_wr    (cpu_tx_wr),
    .cpu_ack      (cpu_ack),
    .cpu_rx_word  (cpu_rx_word),
    .cpu_rx_full  (cpu_rx_full),
    .cpu_tx_ready (cpu_tx_ready),
    .cpu_hreq     (cpu_hreq),
    .cpu_vector   (cpu_vector),
    .rd_data      (rd_data),
    .rd_valid     (rd_valid),
    .wr_lo        (wr_lo),
    .rx_hold      (rx_hold)
  );

  hpb_pin_mux #(.DW(DATA_W), .CW(CFG_W)) pins_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wr   (cpu_cfg_wr),
    .cfg_sel  (cpu_cfg_sel),
    .cfg_data (cpu_cfg_data),
    .pin_in   (pin_in),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .host_en  (host_en),
    .mux_mode (mux_mode),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .gpio_in  (gpio_in)
  );
endmodule

// File: rtl/hpb_bridge_chk.sv
module hpb_bridge_chk #(
  parameter int DW = 8,
  parameter int WW = 24,
  parameter int VW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_hreq,
  input logic          cpu_ack,
  input logic [VW-1:0] cpu_vector,
  input logic          cpu_rx_full,
  input logic [WW-1:0] cpu_rx_word,
  input logic          wr_lo,
  input logic          cpu_tx_ready,
  input logic [WW-1:0] rx_hold,
  input logic          host_en,
  input logic [DW-1:0] pin_oe,
  input logic          rd_strobe
);
  // R6
  hreq_ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_hreq && cpu_ack |=> !cpu_hreq);

  // R7
  vector_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_hreq && !cpu_ack |=> cpu_hreq && $stable(cpu_vector));

  // R2
  rx_full_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_rx_full) |-> $past(wr_lo));

  // R3
  rx_word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rx_full |=> $stable(cpu_rx_word));

  // R5
  tx_word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_tx_ready |=> $stable(rx_hold));

  // R11
  read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_en && (pin_oe != '0) |-> $past(rd_strobe));
endmodule

bind hpb_bridge hpb_bridge_chk #(.DW(DATA_W), .WW(DATA_W*NBYTES), .VW(VEC_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .cpu_hreq     (cpu_hreq),
  .cpu_ack      (cpu_ack),
  .cpu_vector   (cpu_vector),
  .cpu_rx_full  (cpu_rx_full),
  .cpu_rx_word  (cpu_rx_word),
  .wr_lo        (wr_lo),
  .cpu_tx_ready (cpu_tx_ready),
  .rx_hold      (rx_hold),
  .host_en      (host_en),
  .pin_oe       (pin_oe),
  .rd_strobe    (acc.rd)
);

// File: tb/hpb_bridge_tb_top.sv
module hpb_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        hcs, hwr, hale;
  logic [2:0]  haddr;
  logic [7:0]  pin_in, pin_out, pin_oe, gpio_in;
  logic [23:0] cpu_rx_word, cpu_tx_word;
  logic        cpu_rx_full, cpu_rx_rd, cpu_tx_wr, cpu_tx_ready;
  logic        cpu_hreq, cpu_ack, cpu_cfg_wr;
  logic [6:0]  cpu_vector;
  logic [1:0]  cpu_cfg_sel;
  logic [15:0] cpu_cfg_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  hpb_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .hcs(hcs), .hwr(hwr), .hale(hale), .haddr(haddr),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .cpu_rx_word(cpu_rx_word), .cpu_rx_full(cpu_rx_full), .cpu_rx_rd(cpu_rx_rd),
    .cpu_tx_word(cpu_tx_word), .cpu_tx_wr(cpu_tx_wr), .cpu_tx_ready(cpu_tx_ready),
    .cpu_hreq(cpu_hreq), .cpu_vector(cpu_vector), .cpu_ack(cpu_ack),
    .cpu_cfg_wr(cpu_cfg_wr), .cpu_cfg_sel(cpu_cfg_sel), .cpu_cfg_data(cpu_cfg_data),
    .gpio_in(gpio_in)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); hcs = 1'b1; hwr = 1'b1; haddr = a; pin_in = d;
    @(negedge clk); hcs = 1'b0; hwr = 1'b0;
  endtask

  task automatic host_rd(input logic [2:0] a, output logic [7:0] d, output logic [7:0] oe);
    @(negedge clk); hcs = 1'b1; hwr = 1'b0; haddr = a;
    @(negedge clk); hcs = 1'b0;
    d = pin_out; oe = pin_oe;
  endtask

  task automatic host_latch(input logic [2:0] a);
    @(negedge clk); hale = 1'b1; pin_in = {5'b0, a};
    @(negedge clk); hale = 1'b0;
  endtask

  task automatic cpu_push(input logic [23:0] w);
    @(negedge clk); cpu_tx_word = w; cpu_tx_wr = 1'b1;
    @(negedge clk); cpu_tx_wr = 1'b0;
  endtask

  task automatic cpu_pop();
    @(negedge clk); cpu_rx_rd = 1'b1;
    @(negedge clk); cpu_rx_rd = 1'b0;
  endtask

  task automatic cpu_acknowledge();
    @(negedge clk); cpu_ack = 1'b1;
    @(negedge clk); cpu_ack = 1'b0;
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk); cpu_cfg_wr = 1'b1; cpu_cfg_sel = sel; cpu_cfg_data = d;
    @(negedge clk); cpu_cfg_wr = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 pin_oe in reset", {24'b0, pin_oe}, 32'h0);
    check("R1 rx_full in reset", {31'b0, cpu_rx_full}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1 pin_oe after reset", {24'b0, pin_oe}, 32'h0);
    check("R1 tx_ready", {31'b0, cpu_tx_ready}, 32'h1);
    check("R1 hreq", {31'b0, cpu_hreq}, 32'h0);
  endtask

  task automatic t_status_idle();
    logic [7:0] d, oe;
    cfg(2'd0, 16'h0001);
    host_rd(3'd1, d, oe);
    check("R8 idle status", {24'b0, d}, 32'h02);
    check("R11 oe during read", {24'b0, oe}, 32'hFF);
    @(negedge clk);
    check("R11 oe after read", {24'b0, pin_oe}, 32'h00);
  endtask

  task automatic t_host_to_cpu();
    logic [7:0] d, oe;
    host_wr(3'd5, 8'hA1);
    host_wr(3'd6, 8'hB2);
    check("R2 not full before low", {31'b0, cpu_rx_full}, 32'h0);
    host_wr(3'd7, 8'hC3);
    check("R2 rx_full", {31'b0, cpu_rx_full}, 32'h1);
    check("R2 word", {8'b0, cpu_rx_word}, 32'hA1B2C3);
    host_rd(3'd1, d, oe);
    check("R2 write-allowed cleared", {24'b0, d}, 32'h00);
  endtask

  task automatic t_tx_guard();
    host_wr(3'd5, 8'h55);
    check("R3 word held while full", {8'b0, cpu_rx_word}, 32'hA1B2C3);
    cpu_pop();
    check("R3 pop clears full", {31'b0, cpu_rx_full}, 32'h0);
    host_wr(3'd7, 8'h77);
    check("R3 high byte write was dropped", {8'b0, cpu_rx_word}, 32'hA1B277);
    cpu_pop();
  endtask

  task automatic t_stat_ro();
    logic [7:0] d, oe;
    host_wr(3'd1, 8'hFF);
    host_rd(3'd1, d, oe);
    check("R8 status write ignored", {24'b0, d}, 32'h02);
  endtask

  task automatic t_cpu_to_host();
    logic [7:0] d, oe;
    cpu_push(24'h123456);
    check("R4 tx_ready low", {31'b0, cpu_tx_ready}, 32'h0);
    host_rd(3'd1, d, oe);
    check("R4 status read-allowed", {24'b0, d}, 32'h03);
    host_rd(3'd5, d, oe);
    check("R4 high byte", {24'b0, d}, 32'h12);
    host_rd(3'd6, d, oe);
    check("R4 middle byte", {24'b0, d}, 32'h34);
    check("R4 still not ready", {31'b0, cpu_tx_ready}, 32'h0);
    host_rd(3'd7, d, oe);
    check("R4 low byte", {24'b0, d}, 32'h56);
    check("R4 ready after low read", {31'b0, cpu_tx_ready}, 32'h1);
    host_rd(3'd1, d, oe);
    check("R4 status after drain", {24'b0, d}, 32'h02);
  endtask

  task automatic t_rx_guard();
    logic [7:0] d, oe;
    cpu_push(24'hABCDEF);
    cpu_push(24'h111111);
    host_rd(3'd5, d, oe);
    check("R5 high kept", {24'b0, d}, 32'hAB);
    host_rd(3'd6, d, oe);
    check("R5 middle kept", {24'b0, d}, 32'hCD);
    host_rd(3'd7, d, oe);
    check("R5 low kept", {24'b0, d}, 32'hEF);
  endtask

  task automatic t_cmd();
    logic [7:0] d, oe;
    host_wr(3'd0, 8'hAA);
    check("R6 hreq set", {31'b0, cpu_hreq}, 32'h1);
    check("R6 vector", {25'b0, cpu_vector}, 32'h2A);
    host_rd(3'd1, d, oe);
    check("R8 status with request", {24'b0, d}, 32'h06);
    host_wr(3'd0, 8'h95);
    check("R7 vector held", {25'b0, cpu_vector}, 32'h2A);
    host_rd(3'd0, d, oe);
    check("R7 command readback", {24'b0, d}, 32'hAA);
    cpu_acknowledge();
    check("R6 ack clears", {31'b0, cpu_hreq}, 32'h0);
    host_wr(3'd0, 8'h15);
    check("R6 vector after ack", {25'b0, cpu_vector}, 32'h15);
    check("R6 no request without bit 7", {31'b0, cpu_hreq}, 32'h0);
  endtask

  task automatic t_mux();
    logic [7:0] d, oe;
    cfg(2'd0, 16'h0003);
    host_latch(3'd5); host_wr(3'd1, 8'h11);
    host_latch(3'd6); host_wr(3'd1, 8'h22);
    host_latch(3'd7); host_wr(3'd1, 8'h33);
    check("R9 mux word", {8'b0, cpu_rx_word}, 32'h112233);
    host_latch(3'd1);
    host_rd(3'd7, d, oe);
    check("R9 mux status read", {24'b0, d}, 32'h00);
    cpu_pop();
  endtask

  task automatic t_gpio();
    logic [7:0] d, oe;
    cfg(2'd0, 16'h0000);
    cfg(2'd1, 16'h000F);
    cfg(2'd2, 16'h005A);
    check("R10 oe from direction", {24'b0, pin_oe}, 32'h0F);
    check("R10 output data", {24'b0, pin_out & pin_oe}, 32'h0A);
    @(negedge clk); pin_in = 8'hC3;
    @(negedge clk);
    check("R10 gpio_in", {24'b0, gpio_in}, 32'hC3);
    host_wr(3'd7, 8'h99);
    check("R10 host write ignored", {31'b0, cpu_rx_full}, 32'h0);
    host_rd(3'd1, d, oe);
    check("R10 host read ignored", {24'b0, oe}, 32'h0F);
  endtask

  initial begin
    rst_n = 1'b0; hcs = 1'b0; hwr = 1'b0; hale = 1'b0; haddr = 3'd0;
    pin_in = 8'h00; cpu_rx_rd = 1'b0; cpu_tx_wr = 1'b0; cpu_tx_word = '0;
    cpu_ack = 1'b0; cpu_cfg_wr = 1'b0; cpu_cfg_sel = 2'd0; cpu_cfg_data = '0;
    repeat (3) @(negedge clk);
    t_reset();
    t_status_idle();
    t_host_to_cpu();
    t_tx_guard();
    t_stat_ro();
    t_cpu_to_host();
    t_rx_guard();
    t_cmd();
    t_mux();
    t_gpio();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule